// File: doc/BRIEF.md
# Subblock Checksum Scanner

This block checks a storage block for damage before any error-correction decoding is spent on it. The block arrives one byte per accepted cycle. It holds a data area of several fixed-size subblocks, then all of the correction parity for those subblocks packed together, then a trailer of stored CRC32 values. The scanner computes the same CRC32 values as the bytes go by. At the end it reports which subblocks still need a full correction decode.

Three layers of checksum are compared. One covers the whole data area, one covers the packed parity area, and one covers each subblock. A match on the whole-area checksum clears the decode mask entirely. Otherwise each subblock is flagged on its own result. A mismatch on the parity checksum raises a flag that tells downstream logic not to trust the parity for this block. The number of parity bytes per subblock is chosen per block through an input sampled at start. The correction decoder itself lies outside this block.

Top module: `sbcrc_scan`

## Requirements
- R1: After `start`, the stream is taken in this fixed order:
  - `NUM_SUB` times `SUB_BYTES` data bytes, subblock 0 first;
  - `NUM_SUB` times `nRoots` parity bytes;
  - the 4-byte stored CRC of the data area;
  - the 4-byte stored CRC of the parity area;
  - `NUM_SUB` 4-byte stored subblock CRCs in subblock index order.
  
  Every stored CRC is sent least significant byte first.
- R2: Every CRC is the reflected CRC32: polynomial 0xEDB88320, initial value 0xFFFFFFFF, final XOR 0xFFFFFFFF, bytes processed least significant bit first.
- R3: When the data-area CRC mismatches, bit i of `needDecode` is 1 exactly when the stored CRC of subblock i differs from the CRC computed over that subblock's data bytes.
- R4: When the data-area CRC matches, `needDecode` is all zeros whatever the subblock comparisons give.
- R5: `paritySuspect` is 1 exactly when the stored parity CRC differs from the CRC computed over the parity area. With `nRoots` = 0 the parity area is empty and its expected CRC is 0x00000000.
- R6: `blockOk` is 1 exactly when the stored data-area CRC matches the computed one.
- R7: `done` is a one-cycle pulse in the cycle after the last trailer byte is accepted. The results appear together with it and hold until the next `start`. The cycle after `start`, all results and `done` are 0.
- R8: A byte is consumed only when `inValid` is 1. Bytes offered while no block is open (before the first `start` or after `done`) change nothing.
- R9: `start` abandons any block in progress and begins a new one; the byte offered in the `start` cycle is not consumed. `nRoots` is sampled only in the `start` cycle.
- R10: While `rstN` is low and after its release, `done`, `needDecode`, `paritySuspect` and `blockOk` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new block |
| nRoots | input | 8 | Parity bytes per subblock, sampled with start |
| inValid | input | 1 | inByte holds a stream byte this cycle |
| inByte | input | 8 | Stream byte |
| done | output | 1 | One-cycle pulse when results are ready |
| needDecode | output | NUM_SUB | Per-subblock decode-required mask |
| paritySuspect | output | 1 | Parity-area CRC mismatch |
| blockOk | output | 1 | Data-area CRC match |

## Verification
A table of blocks is run through the scanner. Each block flips chosen bits in:
- the data of one or two subblocks;
- one parity byte;
- a stored subblock CRC;
- the stored data-area CRC;
- the stored parity CRC.

A data flip separates per-subblock flagging from the whole-area result. A flipped stored subblock CRC with an intact data area shows that the whole-area match overrides the mask. The same flip combined with a broken data-area CRC shows that the mask follows the subblock compare. Parity sizes 0, 2, 4, 8, 16, 32 and 255 test the empty and the largest parity area. Directed runs restart a block part-way through, offer bytes while idle, and leave gaps in `inValid`.

// File: rtl/sbcrc_pkg.sv
package sbcrc_pkg;

  localparam int MAX_SUB   = 32;
  localparam int SUB_IDX_W = 5;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    S_IDLE, S_DATA, S_PAR, S_CKW, S_CKP, S_CKS
  } scanState_e;

  typedef enum logic [1:0] {
    CK_WHOLE, CK_PAR, CK_SUB
  } ckKind_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic                 clear;
    logic                 dataByte;
    logic                 subLast;
    logic                 parByte;
    logic                 ckByte;
    logic                 ckLast;
    ckKind_e              ckKind;
    logic [SUB_IDX_W-1:0] subIdx;
    logic                 finish;
  } strobe_t;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = (r >> 1) ^ (r[0] ? CRC_POLY : 32'd0);
    end
    return r;
  endfunction

endpackage

// File: rtl/sbcrc_ctrl.sv
module sbcrc_ctrl
  import sbcrc_pkg::*;
#(
  parameter int NUM_SUB   = 8,
  parameter int SUB_BYTES = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] nRoots,
  input  logic       inValid,
  output strobe_t    st
);

  localparam int SPAN  = (NUM_SUB * 256 > SUB_BYTES) ? NUM_SUB * 256 : SUB_BYTES;
  localparam int CNT_W = $clog2(SPAN) + 1;
  localparam logic [CNT_W-1:0]     SUB_LAST = CNT_W'(SUB_BYTES - 1);
  localparam logic [SUB_IDX_W-1:0] IDX_LAST = SUB_IDX_W'(NUM_SUB - 1);

  scanState_e           state;
  logic [CNT_W-1:0]     byteCnt;
  logic [CNT_W-1:0]     parTotal;
  logic [SUB_IDX_W-1:0] subIdx;
  logic                 take;
  logic                 fieldEnd;

  assign take     = inValid && !start;
  assign fieldEnd = (byteCnt == CNT_W'(3));

  always_comb begin
    st        = '0;
    st.clear  = start;
    st.subIdx = subIdx;
    if (take) begin
      unique case (state)
        S_DATA: begin
          st.dataByte = 1'b1;
          st.subLast  = (byteCnt == SUB_LAST);
        end
        S_PAR: st.parByte = 1'b1;
        S_CKW: begin
          st.ckByte = 1'b1;
          st.ckLast = fieldEnd;
          st.ckKind = CK_WHOLE;
        end
        S_CKP: begin
          st.ckByte = 1'b1;
          st.ckLast = fieldEnd;
          st.ckKind = CK_PAR;
        end
        S_CKS: begin
          st.ckByte = 1'b1;
          st.ckLast = fieldEnd;
          st.ckKind = CK_SUB;
          st.finish = fieldEnd && (subIdx == IDX_LAST);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      byteCnt  <= '0;
      parTotal <= '0;
      subIdx   <= '0;
    end else if (start) begin
      state    <= S_DATA;
      byteCnt  <= '0;
      subIdx   <= '0;
      parTotal <= CNT_W'(NUM_SUB) * CNT_W'(nRoots);
    end else if (take) begin
      unique case (state)
        S_DATA: begin
          if (byteCnt == SUB_LAST) begin
            byteCnt <= '0;
            if (subIdx == IDX_LAST) begin
              subIdx <= '0;
              state  <= (parTotal == '0) ? S_CKW : S_PAR;
            end else begin
              subIdx <= subIdx + 1'b1;
            end
          end else begin
            byteCnt <= byteCnt + 1'b1;
          end
        end
        S_PAR: begin
          if (byteCnt == parTotal - 1'b1) begin
            byteCnt <= '0;
            state   <= S_CKW;
          end else begin
            byteCnt <= byteCnt + 1'b1;
          end
        end
        S_CKW, S_CKP: begin
          if (fieldEnd) begin
            byteCnt <= '0;
            state   <= (state == S_CKW) ? S_CKP : S_CKS;
          end else begin
            byteCnt <= byteCnt + 1'b1;
          end
        end
        S_CKS: begin
          if (fieldEnd) begin
            byteCnt <= '0;
            if (subIdx == IDX_LAST) begin
              subIdx <= '0;
              state  <= S_IDLE;
            end else begin
              subIdx <= subIdx + 1'b1;
            end
          end else begin
            byteCnt <= byteCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sbcrc_datapath.sv
module sbcrc_datapath
  import sbcrc_pkg::*;
#(
  parameter int NUM_SUB = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [7:0]         inByte,
  output logic               done,
  output logic [NUM_SUB-1:0] needDecode,
  output logic               paritySuspect,
  output logic               blockOk
);

  logic [31:0]        wholeCrc;
  logic [31:0]        parCrc;
  logic [31:0]        subRun;
  logic [31:0]        subNext;
  logic [23:0]        ckShift;
  logic [31:0]        ckWord;
  logic               wholeMatch;
  logic               parMatch;
  logic               fieldEnd;
  logic [NUM_SUB-1:0] misNext;

  assign subNext  = crcStep(subRun, inByte);
  assign ckWord   = {inByte, ckShift};
  assign fieldEnd = st.ckByte && st.ckLast;

  // per-subblock computed CRC and mismatch flag
  for (genvar i = 0; i < NUM_SUB; i++) begin : g_sub
    logic [31:0] storedCrc;
    logic        misBit;
    logic        hit;

    assign hit = (st.subIdx == SUB_IDX_W'(i));
    assign misNext[i] = misBit |
      (fieldEnd && st.ckKind == CK_SUB && hit && ckWord != storedCrc);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        storedCrc <= '0;
        misBit    <= 1'b0;
      end else if (st.clear) begin
        misBit    <= 1'b0;
      end else begin
        if (st.dataByte && st.subLast && hit) storedCrc <= ~subNext;
        misBit <= misNext[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wholeCrc      <= CRC_SEED;
      parCrc        <= CRC_SEED;
      subRun        <= CRC_SEED;
      ckShift       <= '0;
      wholeMatch    <= 1'b0;
      parMatch      <= 1'b0;
      done          <= 1'b0;
      needDecode    <= '0;
      paritySuspect <= 1'b0;
      blockOk       <= 1'b0;
    end else if (st.clear) begin
      wholeCrc      <= CRC_SEED;
      parCrc        <= CRC_SEED;
      subRun        <= CRC_SEED;
      ckShift       <= '0;
      wholeMatch    <= 1'b0;
      parMatch      <= 1'b0;
      done          <= 1'b0;
      needDecode    <= '0;
      paritySuspect <= 1'b0;
      blockOk       <= 1'b0;
    end else begin
      done <= st.finish;
      if (st.dataByte) begin
        wholeCrc <= crcStep(wholeCrc, inByte);
        subRun   <= st.subLast ? CRC_SEED : subNext;
      end
      if (st.parByte) parCrc <= crcStep(parCrc, inByte);
      if (st.ckByte) ckShift <= {inByte, ckShift[23:8]};
      if (fieldEnd && st.ckKind == CK_WHOLE) wholeMatch <= (ckWord == ~wholeCrc);
      if (fieldEnd && st.ckKind == CK_PAR)   parMatch   <= (ckWord == ~parCrc);
      if (st.finish) begin
        needDecode    <= wholeMatch ? '0 : misNext;
        paritySuspect <= !parMatch;
        blockOk       <= wholeMatch;
      end
    end
  end

endmodule

// File: rtl/sbcrc_scan.sv
module sbcrc_scan
  import sbcrc_pkg::*;
#(
  parameter int NUM_SUB   = 8,
  parameter int SUB_BYTES = 128
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [7:0]         nRoots,
  input  logic               inValid,
  input  logic [7:0]         inByte,
  output logic               done,
  output logic [NUM_SUB-1:0] needDecode,
  output logic               paritySuspect,
  output logic               blockOk
);

  strobe_t st;

  initial begin
    if (NUM_SUB < 1 || NUM_SUB > MAX_SUB) $error("NUM_SUB out of range");
  end

  sbcrc_ctrl #(.NUM_SUB(NUM_SUB), .SUB_BYTES(SUB_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .nRoots(nRoots),
    .inValid(inValid), .st(st)
  );

  sbcrc_datapath #(.NUM_SUB(NUM_SUB)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inByte(inByte),
    .done(done), .needDecode(needDecode),
    .paritySuspect(paritySuspect), .blockOk(blockOk)
  );

endmodule

// File: rtl/sbcrc_scan_sva.sv
module sbcrc_scan_sva #(
  parameter int NUM_SUB = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               done,
  input logic [NUM_SUB-1:0] needDecode,
  input logic               paritySuspect,
  input logic               blockOk
);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_mask_clear_on_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    blockOk |-> needDecode == '0);

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!done && needDecode == '0 && !paritySuspect && !blockOk));

  p_hold_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (done || $stable(needDecode)));

  p_hold_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (done || ($stable(paritySuspect) && $stable(blockOk))));

endmodule

bind sbcrc_scan sbcrc_scan_sva #(.NUM_SUB(NUM_SUB)) u_sva (
  .clk(clk), .rstN(rstN), .start(start), .done(done),
  .needDecode(needDecode), .paritySuspect(paritySuspect), .blockOk(blockOk)
);

// File: tb/sbcrc_scan_bench.sv
module sbcrc_scan_bench;

  localparam int NSUB = 8;
  localparam int SB   = 128;
  localparam int DLEN = NSUB * SB;

  typedef struct packed {
    logic [7:0] nr;
    logic [5:0] flags;  // b0 data A, b1 data B, b2 parity, b3 stored sub A, b4 stored whole, b5 stored parity
    logic [2:0] a;
    logic [2:0] b;
    logic [7:0] mask;
    logic       susp;
    logic       ok;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd16,  6'b000000, 3'd0, 3'd0, 8'h00, 1'b0, 1'b1},
    '{8'd16,  6'b000001, 3'd3, 3'd0, 8'h08, 1'b0, 1'b0},
    '{8'd4,   6'b000011, 3'd2, 3'd5, 8'h24, 1'b0, 1'b0},
    '{8'd8,   6'b000100, 3'd0, 3'd0, 8'h00, 1'b1, 1'b1},
    '{8'd8,   6'b001000, 3'd6, 3'd0, 8'h00, 1'b0, 1'b1},
    '{8'd2,   6'b011000, 3'd6, 3'd0, 8'h40, 1'b0, 1'b0},
    '{8'd0,   6'b000000, 3'd0, 3'd0, 8'h00, 1'b0, 1'b1},
    '{8'd0,   6'b100000, 3'd0, 3'd0, 8'h00, 1'b1, 1'b1},
    '{8'd32,  6'b000011, 3'd0, 3'd7, 8'h81, 1'b0, 1'b0},
    '{8'd255, 6'b110000, 3'd0, 3'd0, 8'h00, 1'b1, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [7:0]      nRoots = '0;
  logic            inValid = 1'b0;
  logic [7:0]      inByte = '0;
  logic            done;
  logic [NSUB-1:0] needDecode;
  logic            paritySuspect;
  logic            blockOk;

  int total = 0;
  int bad = 0;
  int doneSeen = 0;
  logic [7:0] blk [0:4095];

  always #2.5 clk = ~clk;

  always @(posedge clk) if (done) doneSeen++;

  sbcrc_scan #(.NUM_SUB(NSUB), .SUB_BYTES(SB)) u_sbcrc_scan (
    .clk(clk), .rstN(rstN), .start(start), .nRoots(nRoots),
    .inValid(inValid), .inByte(inByte), .done(done),
    .needDecode(needDecode), .paritySuspect(paritySuspect), .blockOk(blockOk)
  );

  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseStart(input logic [7:0] nr);
    @(negedge clk);
    start = 1'b1; nRoots = nr; inValid = 1'b1; inByte = 8'hC3;
    @(negedge clk);
    start = 1'b0; inValid = 1'b0;
    nRoots = 8'hA5;  // later changes must be ignored (R9)
  endtask

  task automatic sendByte(input logic [7:0] b, input int k);
    inValid = 1'b1; inByte = b;
    @(negedge clk);
    inValid = 1'b0;
    if (k % 97 == 5) @(negedge clk);  // gap, nothing consumed (R8)
  endtask

  task automatic putWord(input int at, input logic [31:0] w);
    for (int k = 0; k < 4; k++) blk[at + k] = w[8*k +: 8];
  endtask

  task automatic runBlock(input vec_t v, input int seed, input string tag);
    int plen;
    int len;
    logic [31:0] cw, cp, cs;
    logic [31:0] subs [NSUB];
    plen = NSUB * int'(v.nr);
    for (int i = 0; i < DLEN; i++) blk[i] = 8'((i * 37) + (seed * 11) + (i >> 3));
    for (int j = 0; j < plen; j++) blk[DLEN + j] = 8'((j * 91) + seed + 5);
    cw = 32'hFFFFFFFF;
    for (int i = 0; i < DLEN; i++) cw = refCrc(cw, blk[i]);
    cw = ~cw;
    cp = 32'hFFFFFFFF;
    for (int j = 0; j < plen; j++) cp = refCrc(cp, blk[DLEN + j]);
    cp = ~cp;
    for (int s = 0; s < NSUB; s++) begin
      cs = 32'hFFFFFFFF;
      for (int i = 0; i < SB; i++) cs = refCrc(cs, blk[s * SB + i]);
      subs[s] = ~cs;
    end
    if (v.flags[0]) blk[int'(v.a) * SB + 7]   ^= 8'h10;
    if (v.flags[1]) blk[int'(v.b) * SB + 100] ^= 8'h01;
    if (v.flags[2]) blk[DLEN] ^= 8'h80;
    if (v.flags[3]) subs[v.a] ^= 32'h1;
    if (v.flags[4]) cw ^= 32'h0000_0100;
    if (v.flags[5]) cp ^= 32'h8000_0000;
    putWord(DLEN + plen, cw);
    putWord(DLEN + plen + 4, cp);
    for (int s = 0; s < NSUB; s++) putWord(DLEN + plen + 8 + 4 * s, subs[s]);
    len = DLEN + plen + 8 + 4 * NSUB;
    pulseStart(v.nr);
    for (int k = 0; k < len - 1; k++) sendByte(blk[k], k);
    check({tag, " R1 no early done"}, 32'(doneSeen != 0 ? done : 1'b0), 32'd0);
    inValid = 1'b1; inByte = blk[len - 1];
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " R1 R7 done pulse"}, 32'(done), 32'd1);
    check({tag, " R3 R4 needDecode"}, 32'(needDecode), 32'(v.mask));
    check({tag, " R5 paritySuspect"}, 32'(paritySuspect), 32'(v.susp));
    check({tag, " R6 R2 blockOk"}, 32'(blockOk), 32'(v.ok));
    @(negedge clk);
    check({tag, " R7 done one cycle"}, 32'(done), 32'd0);
    check({tag, " R7 mask held"}, 32'(needDecode), 32'(v.mask));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 done in reset", 32'(done), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 done", 32'(done), 32'd0);
    check("R10 needDecode", 32'(needDecode), 32'd0);
    check("R10 paritySuspect", 32'(paritySuspect), 32'd0);
    check("R10 blockOk", 32'(blockOk), 32'd0);

    // idle bytes before any start (R8)
    doneSeen = 0;
    for (int k = 0; k < 40; k++) sendByte(8'(k), 0);
    check("R8 idle no done", 32'(doneSeen), 32'd0);

    for (int n = 0; n < NV; n++) begin
      doneSeen = 0;
      runBlock(VECS[n], n, $sformatf("vec%0d", n));
      check("R7 single done", 32'(doneSeen), 32'd1);
    end

    // bytes after done are ignored; results held (R8)
    doneSeen = 0;
    for (int k = 0; k < 60; k++) sendByte(8'(k * 3), 0);
    check("R8 post-done no done", 32'(doneSeen), 32'd0);
    check("R8 post-done suspect held", 32'(paritySuspect), 32'd1);
    check("R8 post-done ok held", 32'(blockOk), 32'd0);

    // start clears results (R7)
    pulseStart(8'd4);
    check("R7 start clears suspect", 32'(paritySuspect), 32'd0);
    check("R7 start clears mask", 32'(needDecode), 32'd0);

    // restart mid-block (R9)
    for (int k = 0; k < 300; k++) sendByte(8'h5A, k);
    doneSeen = 0;
    runBlock('{8'd8, 6'b000001, 3'd1, 3'd0, 8'h02, 1'b0, 1'b0}, 21, "restart R9");
    check("R9 restart single done", 32'(doneSeen), 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule